// File: doc/BRIEF.md
# Planar VGA Write Data Path

This block forms the processor-to-frame-buffer write path of a four-plane graphics controller. It holds two small configuration registers behind an index/data register pair: a per-plane fill colour (`setrst`) and a per-plane fill enable (`fill_en`). For every processor write it returns one data byte per plane, already merged with the plane latches, and a write strobe for each plane. The caller supplies the write-mode field, the rotate count and the bit-mask byte from the surrounding controller.

The processor byte is first rotated right. In substitution mode (mode 0), a plane whose fill enable is set takes eight copies of its fill-colour bit, and every other plane takes the rotated byte. The bit-mask byte then chooses which bits are written. In colour mode (mode 3), every plane writes its own fill-colour bit, and the rotated byte ANDed with the bit mask sets which bits are written. In both modes, a bit whose mask is 0 keeps the value of the plane latch. Modes 1 and 2 are not handled here, so they pass the latches through and raise no strobe. The write path is combinational. Register writes take effect at the next clock edge.

Top module: `planar_write_path`

## Requirements
- R1: A pulse on `reg_idx_we` loads `reg_wdata` into the index register. A pulse on `reg_data_we` loads `reg_wdata[3:0]` into the fill-colour register when the index is 00h, or into the fill-enable register when the index is 01h, at the next rising clock edge. A data write at any other index changes neither register.
- R2: `reg_rdata` shows the register that the index selects, with bits 7:4 always zero. Any index other than 00h or 01h reads as 00h.
- R3: After reset, the index, the fill colour and the fill enable are all zero.
- R4: The processor byte is rotated right by `rotate_cnt` (0 to 7) before any other step. Output bit i takes input bit (i+k) mod 8.
- R5: In mode 0 (`write_mode`=2'b00), a plane p whose fill-enable bit p is 1 receives fill-colour bit p on every bit that the mask writes.
- R6: In mode 0, a plane whose fill-enable bit is 0 receives the rotated processor byte on every bit that the mask writes.
- R7: In mode 0, the mask is `bit_mask` alone. Where a mask bit is 0, the output bit equals the same bit of that plane's latch.
- R8: In mode 3 (`write_mode`=2'b11), the mask is the rotated byte ANDed with `bit_mask`. Masked bits of plane p take fill-colour bit p, unmasked bits take the latch, and the fill enable has no effect.
- R9: For modes 0 and 3, `plane_strobe[p]` = `cpu_we` AND `plane_en[p]`.
- R10: In modes 1 and 2, `plane_data` equals `plane_latch` and `plane_strobe` is all zero.
- R11: Plane p occupies bits [8p+7:8p] of `plane_latch` and `plane_data`, and bit p of `plane_en`, `plane_strobe` and both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx_we | input | 1 | Write strobe for the index register |
| reg_data_we | input | 1 | Write strobe for the data port |
| reg_wdata | input | 8 | Write data for index or data port |
| reg_rdata | output | 8 | Read data of the indexed register |
| cpu_we | input | 1 | Processor write to the frame buffer |
| cpu_data | input | 8 | Processor write byte |
| write_mode | input | 2 | Write mode select |
| rotate_cnt | input | 3 | Right-rotate amount |
| bit_mask | input | 8 | Bit-mask byte |
| plane_latch | input | 32 | Latched bytes of the four planes |
| plane_en | input | 4 | Per-plane write enable |
| plane_data | output | 32 | Merged data byte for each plane |
| plane_strobe | output | 4 | Per-plane write strobe |

## Verification
The bench programs all 256 pairs of fill colour and fill enable. For each pair it applies every write mode and every rotate count, with three processor bytes and two bit masks. The asymmetric processor bytes distinguish one rotate amount from another. A sparse mask and the all-ones mask separate latch bits from written bits, and sweeping the fill enable shows whether substitution is limited to enabled planes in mode 0 and ignored in mode 3. Separate register sequences cover writes at other indexes, the zero upper nibble on readback, and the zero state after reset.

// File: rtl/planar_wr_pkg.sv
package planar_wr_pkg;
  typedef enum logic [1:0] {
    WMODE_SUBST  = 2'd0,
    WMODE_ONE    = 2'd1,
    WMODE_TWO    = 2'd2,
    WMODE_COLOUR = 2'd3
  } wmode_e;

  localparam int          IDX_W      = 8;
  localparam logic [7:0]  IDX_SETRST = 8'h00;
  localparam logic [7:0]  IDX_FILLEN = 8'h01;
endpackage

// File: rtl/planar_idx_regs.sv
module planar_idx_regs
  import planar_wr_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic               data_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [IDX_W-1:0]   idx_q,
  output logic [NPLANES-1:0] setrst_q,
  output logic [NPLANES-1:0] fillen_q,
  output logic [DATA_W-1:0]  rdata
);
  localparam int PAD_W = DATA_W - NPLANES;

  logic [IDX_W-1:0]   idx_d;
  logic [NPLANES-1:0] setrst_d;
  logic [NPLANES-1:0] fillen_d;
  logic               idx_en;
  logic               setrst_en;
  logic               fillen_en;

  // Clock enables
  always_comb begin
    idx_en    = idx_we;
    setrst_en = data_we && !idx_we && (idx_q == IDX_SETRST);
    fillen_en = data_we && !idx_we && (idx_q == IDX_FILLEN);
  end

  // Next state
  always_comb begin
    idx_d    = idx_q;
    setrst_d = setrst_q;
    fillen_d = fillen_q;
    if (idx_en)    idx_d    = wdata[IDX_W-1:0];
    if (setrst_en) setrst_d = wdata[NPLANES-1:0];
    if (fillen_en) fillen_d = wdata[NPLANES-1:0];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      setrst_q <= '0;
      fillen_q <= '0;
    end else begin
      idx_q    <= idx_d;
      setrst_q <= setrst_d;
      fillen_q <= fillen_d;
    end
  end

  // Read port: upper bits always zero
  always_comb begin
    case (idx_q)
      IDX_SETRST: rdata = {{PAD_W{1'b0}}, setrst_q};
      IDX_FILLEN: rdata = {{PAD_W{1'b0}}, fillen_q};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/planar_rotator.sv
module planar_rotator #(
  parameter int W   = 8,
  parameter int K_W = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [K_W-1:0] cnt,
  output logic [W-1:0]   dout
);
  // Right rotate: output bit i takes input bit (i+cnt) mod W
  always_comb begin
    for (int i = 0; i < W; i++) begin
      dout[i] = din[(i + int'(cnt)) % W];
    end
  end
endmodule

// File: rtl/planar_plane_mix.sv
module planar_plane_mix
  import planar_wr_pkg::*;
#(
  parameter int W = 8
) (
  input  wmode_e       mode,
  input  logic         fill_en,
  input  logic         fill_bit,
  input  logic [W-1:0] rot,
  input  logic [W-1:0] bit_mask,
  input  logic [W-1:0] latch,
  output logic [W-1:0] dout
);
  logic [W-1:0] src;
  logic [W-1:0] mask;

  always_comb begin
    src  = latch;
    mask = '0;
    unique case (mode)
      WMODE_SUBST: begin
        src  = fill_en ? {W{fill_bit}} : rot;
        mask = bit_mask;
      end
      WMODE_COLOUR: begin
        src  = {W{fill_bit}};
        mask = rot & bit_mask;
      end
      default: begin
        src  = latch;
        mask = '0;
      end
    endcase
  end

  assign dout = (src & mask) | (latch & ~mask);
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import planar_wr_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int BYTE_W  = 8,
  localparam int ROT_W  = $clog2(BYTE_W),
  localparam int BUS_W  = NPLANES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_idx_we,
  input  logic               reg_data_we,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic               cpu_we,
  input  logic [BYTE_W-1:0]  cpu_data,
  input  logic [1:0]         write_mode,
  input  logic [ROT_W-1:0]   rotate_cnt,
  input  logic [BYTE_W-1:0]  bit_mask,
  input  logic [BUS_W-1:0]   plane_latch,
  input  logic [NPLANES-1:0] plane_en,
  output logic [BUS_W-1:0]   plane_data,
  output logic [NPLANES-1:0] plane_strobe
);
  logic [IDX_W-1:0]   idx_q;
  logic [NPLANES-1:0] setrst_q;
  logic [NPLANES-1:0] fillen_q;
  logic [BYTE_W-1:0]  rot_data;
  wmode_e             mode;
  logic               mode_ok;

  assign mode = wmode_e'(write_mode);

  planar_idx_regs #(.NPLANES(NPLANES), .DATA_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (reg_idx_we),
    .data_we  (reg_data_we),
    .wdata    (reg_wdata),
    .idx_q    (idx_q),
    .setrst_q (setrst_q),
    .fillen_q (fillen_q),
    .rdata    (reg_rdata)
  );

  planar_rotator #(.W(BYTE_W)) u_rot (
    .din  (cpu_data),
    .cnt  (rotate_cnt),
    .dout (rot_data)
  );

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    planar_plane_mix #(.W(BYTE_W)) u_mix (
      .mode     (mode),
      .fill_en  (fillen_q[p]),
      .fill_bit (setrst_q[p]),
      .rot      (rot_data),
      .bit_mask (bit_mask),
      .latch    (plane_latch[p*BYTE_W +: BYTE_W]),
      .dout     (plane_data[p*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    mode_ok      = (mode == WMODE_SUBST) || (mode == WMODE_COLOUR);
    plane_strobe = (cpu_we && mode_ok) ? plane_en : '0;
  end
endmodule

// File: rtl/planar_write_path_chk.sv
module planar_write_path_chk
  import planar_wr_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int BYTE_W  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_idx_we,
  input logic                       reg_data_we,
  input logic [BYTE_W-1:0]          reg_wdata,
  input logic [BYTE_W-1:0]          reg_rdata,
  input logic                       cpu_we,
  input logic [1:0]                 write_mode,
  input logic [BYTE_W-1:0]          bit_mask,
  input logic [NPLANES*BYTE_W-1:0]  plane_latch,
  input logic [NPLANES-1:0]         plane_en,
  input logic [NPLANES*BYTE_W-1:0]  plane_data,
  input logic [NPLANES-1:0]         plane_strobe,
  input logic [IDX_W-1:0]           idx_q,
  input logic [NPLANES-1:0]         setrst_q,
  input logic [BYTE_W-1:0]          rot_data
);
  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx_we |=> idx_q == $past(reg_wdata[IDX_W-1:0]));

  p_setrst_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_data_we && !reg_idx_we && idx_q == IDX_SETRST)
      |=> setrst_q == $past(reg_wdata[NPLANES-1:0]));

  p_rdata_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BYTE_W-1:NPLANES] == '0);

  p_keep_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (write_mode == 2'd0)
      |-> ((plane_data ^ plane_latch) & ~{NPLANES{bit_mask}}) == '0);

  p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((plane_strobe & ~plane_en) == '0) && (cpu_we || plane_strobe == '0));

  p_hold_other_modes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (write_mode == 2'd1 || write_mode == 2'd2)
      |-> (plane_data == plane_latch && plane_strobe == '0));

  for (genvar p = 0; p < NPLANES; p++) begin : g_colour
    p_colour_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (write_mode == 2'd3)
        |-> (plane_data[p*BYTE_W +: BYTE_W] & rot_data & bit_mask)
            == ({BYTE_W{setrst_q[p]}} & rot_data & bit_mask));
  end
endmodule

bind planar_write_path planar_write_path_chk #(
  .NPLANES (NPLANES),
  .BYTE_W  (BYTE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_idx_we   (reg_idx_we),
  .reg_data_we  (reg_data_we),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .cpu_we       (cpu_we),
  .write_mode   (write_mode),
  .bit_mask     (bit_mask),
  .plane_latch  (plane_latch),
  .plane_en     (plane_en),
  .plane_data   (plane_data),
  .plane_strobe (plane_strobe),
  .idx_q        (idx_q),
  .setrst_q     (setrst_q),
  .rot_data     (rot_data)
);

// File: tb/planar_write_path_tb.sv
module planar_write_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_idx_we, reg_data_we;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        cpu_we;
  logic [7:0]  cpu_data;
  logic [1:0]  write_mode;
  logic [2:0]  rotate_cnt;
  logic [7:0]  bit_mask;
  logic [31:0] plane_latch;
  logic [3:0]  plane_en;
  logic [31:0] plane_data;
  logic [3:0]  plane_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  planar_write_path u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_idx_we(reg_idx_we), .reg_data_we(reg_data_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_we(cpu_we), .cpu_data(cpu_data), .write_mode(write_mode),
    .rotate_cnt(rotate_cnt), .bit_mask(bit_mask), .plane_latch(plane_latch),
    .plane_en(plane_en), .plane_data(plane_data), .plane_strobe(plane_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rot_r(input logic [7:0] b, input int k);
    logic [15:0] w;
    w = {b, b} >> k;
    return w[7:0];
  endfunction

  function automatic logic [31:0] model(input logic [1:0] m, input logic [3:0] sr,
                                        input logic [3:0] en, input logic [7:0] d,
                                        input int k, input logic [7:0] bm,
                                        input logic [31:0] lat);
    logic [31:0] r;
    logic [7:0]  rd, src, msk, l;
    rd = rot_r(d, k);
    for (int p = 0; p < 4; p++) begin
      l = lat[p*8 +: 8];
      case (m)
        2'd0: begin src = en[p] ? {8{sr[p]}} : rd; msk = bm; end
        2'd3: begin src = {8{sr[p]}}; msk = rd & bm; end
        default: begin src = l; msk = 8'h00; end
      endcase
      r[p*8 +: 8] = (src & msk) | (l & ~msk);
    end
    return r;
  endfunction

  task automatic reg_write(input logic is_idx, input logic [7:0] v);
    @(negedge clk);
    reg_idx_we  = is_idx;
    reg_data_we = !is_idx;
    reg_wdata   = v;
    @(negedge clk);
    reg_idx_we  = 1'b0;
    reg_data_we = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] data_set [3] = '{8'hB4, 8'h01, 8'h6D};
    logic [7:0] mask_set [2] = '{8'hFF, 8'h5A};
    rst_n = 1'b0; reg_idx_we = 0; reg_data_we = 0; reg_wdata = 0;
    cpu_we = 0; cpu_data = 0; write_mode = 0; rotate_cnt = 0;
    bit_mask = 0; plane_latch = 0; plane_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3: reset state, index 0 selects the fill colour, which reads zero
    check("R3 reset setrst", {24'h0, reg_rdata}, 32'h0);
    reg_write(1'b1, 8'h01);
    check("R3 reset fillen", {24'h0, reg_rdata}, 32'h0);

    // R1 / R2: loads and readback with upper bits zero
    reg_write(1'b1, 8'h00);
    reg_write(1'b0, 8'hF9);
    check("R1 R2 setrst readback", {24'h0, reg_rdata}, 32'h09);
    reg_write(1'b1, 8'h01);
    reg_write(1'b0, 8'hA6);
    check("R1 R2 fillen readback", {24'h0, reg_rdata}, 32'h06);
    reg_write(1'b1, 8'h05);
    check("R2 other index reads zero", {24'h0, reg_rdata}, 32'h0);
    reg_write(1'b0, 8'h0F);
    reg_write(1'b1, 8'h00);
    check("R1 foreign index leaves setrst", {24'h0, reg_rdata}, 32'h09);
    reg_write(1'b1, 8'h01);
    check("R1 foreign index leaves fillen", {24'h0, reg_rdata}, 32'h06);

    // Sweep: fill colour x fill enable x mode x rotate x data x mask
    plane_latch = 32'hC3_96_3C_E1;
    for (int sr = 0; sr < 16; sr++) begin
      for (int en = 0; en < 16; en++) begin
        reg_write(1'b1, 8'h00);
        reg_write(1'b0, 8'(sr));
        reg_write(1'b1, 8'h01);
        reg_write(1'b0, 8'(en));
        for (int m = 0; m < 4; m++) begin
          for (int k = 0; k < 8; k++) begin
            for (int di = 0; di < 3; di++) begin
              for (int mi = 0; mi < 2; mi++) begin
                write_mode = 2'(m);
                rotate_cnt = 3'(k);
                cpu_data   = data_set[di];
                bit_mask   = mask_set[mi];
                cpu_we     = 1'((k + di) % 2);
                plane_en   = 4'(sr ^ (k * 3));
                #1;
                if (m == 3)
                  check("R8 R11 colour mode data", plane_data,
                        model(2'(m), 4'(sr), 4'(en), cpu_data, k, bit_mask, plane_latch));
                else if (m == 0 && en == 0 && mi == 0)
                  check("R4 R6 rotated data", plane_data,
                        model(2'(m), 4'(sr), 4'(en), cpu_data, k, bit_mask, plane_latch));
                else if (m == 0)
                  check("R5 R6 R7 substitution data", plane_data,
                        model(2'(m), 4'(sr), 4'(en), cpu_data, k, bit_mask, plane_latch));
                else
                  check("R10 latch passthrough", plane_data, plane_latch);
                if (m == 0 || m == 3)
                  check("R9 strobe", {28'h0, plane_strobe}, {28'h0, cpu_we ? plane_en : 4'h0});
                else
                  check("R10 no strobe", {28'h0, plane_strobe}, 32'h0);
              end
            end
          end
        end
        plane_latch = {plane_latch[30:0], plane_latch[31]} ^ 32'h0101_0101;
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule